// File: doc/BRIEF.md
# Dual Mailbox Bypass Registers

This block carries short command words between ports without passing them through the data queues. It has two mail slots. The forward slot is loaded from the 36-bit port A and emptied by the narrower port B. The return slot is loaded from the narrower port C and emptied by port A. Each slot has an active-low full flag. A write is accepted only while that flag is HIGH, and it drives the flag LOW. The flag goes HIGH again only when the other side reads the slot.

Each port has a mailbox-select input. With the select HIGH, a transfer goes to the mail slot. With it LOW, the transfer becomes a queue strobe, and the port's registered output shows the queue data instead of the mail word. The static size inputs of port B and port C choose word (18-bit) or byte (9-bit) mode. Size-B sets the lanes of the forward slot and size-C sets the lanes of the return slot. Lanes that the selected mode does not use are ignored on input and driven to zero on output. The byte ordering that applies to queue data does not apply to mail transfers.

All logic runs on one clock with a synchronous active-high reset.

Top module: `mbx_dual_mailbox`

## Requirements
- R1: After reset both flags are HIGH, both registered data outputs are zero, and both mail slots hold zero.
- R2: A port A write (`a_en`=1, `a_wr`=1) with `a_mb`=1 while `mb1_full_n` is HIGH stores the word, and `mb1_full_n` is LOW after that edge. A port C write (`c_wen`=1) with `c_mb`=1 while `mb2_full_n` is HIGH does the same for the return slot and `mb2_full_n`.
- R3: A mail write while the slot's flag is LOW is dropped. The earlier word survives and is returned by the next read.
- R4: A port B read (`b_ren`=1) with `b_mb`=1 drives `mb1_full_n` HIGH after the edge. A port A read (`a_en`=1, `a_wr`=0) with `a_mb`=1 does the same for `mb2_full_n`. If an accepted write and a read of the same slot fall on one edge, the write wins and the flag ends LOW.
- R5: Reading a slot never changes its contents. Repeated reads return the same word.
- R6: Forward slot lanes: in word mode (`size_b`=0) it stores `a_din[17:0]` and presents it on `b_dout[17:0]`. In byte mode (`size_b`=1) it stores `a_din[8:0]` and presents it on `b_dout[8:0]`, with `b_dout[17:9]` zero.
- R7: Return slot lanes: in word mode (`size_c`=0) it stores `c_din[17:0]` and presents it on `a_dout[35:18]`. In byte mode (`size_c`=1) it stores `c_din[8:0]` and presents it on `a_dout[26:18]`. All other `a_dout` bits are zero.
- R8: One edge after the sample, a port output equals the mail word when its `oe`=1 and its mailbox select is 1. It equals the queue data input when `oe`=1 and the select is 0. It is zero when `oe`=0.
- R9: With the mailbox select LOW, a transfer raises the matching queue strobe in the same cycle and leaves the mail flags unchanged. The strobes are `q1_push` (A write), `q1_pop` (B read), `q2_push` (C write) and `q2_pop` (A read). With the select HIGH, no queue strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_b | input | 1 | Port B size: 0 word, 1 byte (static) |
| size_c | input | 1 | Port C size: 0 word, 1 byte (static) |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mb | input | 1 | Port A mailbox select |
| a_oe | input | 1 | Port A output enable |
| a_din | input | 36 | Port A write data |
| a_q_dout | input | 36 | Queue data offered to port A |
| a_dout | output | 36 | Port A registered read data |
| b_ren | input | 1 | Port B read strobe |
| b_mb | input | 1 | Port B mailbox select |
| b_oe | input | 1 | Port B output enable |
| b_q_dout | input | 18 | Queue data offered to port B |
| b_dout | output | 18 | Port B registered read data |
| c_wen | input | 1 | Port C write strobe |
| c_mb | input | 1 | Port C mailbox select |
| c_din | input | 18 | Port C write data |
| mb1_full_n | output | 1 | Forward slot flag, LOW when full |
| mb2_full_n | output | 1 | Return slot flag, LOW when full |
| q1_push | output | 1 | Queue strobe: A write to forward queue |
| q1_pop | output | 1 | Queue strobe: B read from forward queue |
| q2_push | output | 1 | Queue strobe: C write to return queue |
| q2_pop | output | 1 | Queue strobe: A read from return queue |

## Verification
The bench builds the block with its default parameters: a 36-bit port A, 18-bit narrow ports and a 9-bit byte lane. These widths let a single test word carry distinct patterns in every lane. As a result, any bit that leaks across a lane boundary in byte mode, or lands at the wrong offset on port A, shows up as a mismatch. The narrow width equals the slot width, so the forward output steering is exercised with a zero lane offset, while the return path uses the non-zero offset of 18.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    SZ_WORD = 1'b0,
    SZ_BYTE = 1'b1
  } bus_size_e;

  localparam int unsigned WIDE_W_DEF   = 36;
  localparam int unsigned NARROW_W_DEF = 18;
  localparam int unsigned BYTE_W_DEF   = 9;
endpackage

// File: rtl/mbx_mail_slot.sv
module mbx_mail_slot #(
  parameter int unsigned W  = 18,
  parameter int unsigned BW = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         byte_mode,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  input  logic         rd_req,
  output logic [W-1:0] data,
  output logic         full_n
);
  localparam logic [W-1:0] BYTE_MASK = {{(W-BW){1'b0}}, {BW{1'b1}}};

  logic         wr_accept;
  logic [W-1:0] lane_mask;

  assign wr_accept = wr_req & full_n;
  assign lane_mask = byte_mode ? BYTE_MASK : {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      full_n <= 1'b1;
    end else if (wr_accept) begin
      data   <= wr_data & lane_mask;
      full_n <= 1'b0;
    end else if (rd_req) begin
      full_n <= 1'b1;
    end
  end

  assert_fill_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full_n) |=> !full_n);
  assert_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !full_n) |=> $stable(data));
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !(wr_req && full_n)) |=> full_n);
  assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_req) |=> $stable(data));
  assert_byte_lane_R6_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full_n && byte_mode) |=> (data[W-1:BW] == '0));
endmodule

// File: rtl/mbx_out_steer.sv
module mbx_out_steer #(
  parameter int unsigned OUT_W   = 18,
  parameter int unsigned MAIL_W  = 18,
  parameter int unsigned LANE_LO = 0,
  parameter int unsigned BW      = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe,
  input  logic              mb,
  input  logic              byte_mode,
  input  logic [MAIL_W-1:0] mail,
  input  logic [OUT_W-1:0]  q_data,
  output logic [OUT_W-1:0]  dout
);
  localparam logic [OUT_W-1:0] BYTE_LANES = OUT_W'({BW{1'b1}}) << LANE_LO;
  localparam logic [OUT_W-1:0] WORD_LANES = OUT_W'({MAIL_W{1'b1}}) << LANE_LO;

  logic [OUT_W-1:0] placed;
  logic [OUT_W-1:0] nxt;

  assign placed = (OUT_W'(mail) << LANE_LO) & (byte_mode ? BYTE_LANES : WORD_LANES);

  always_comb begin
    if (!oe)     nxt = '0;
    else if (mb) nxt = placed;
    else         nxt = q_data;
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= nxt;
  end

  assert_lane_zero_R6_R7: assert property (@(posedge clk) disable iff (rst)
    (oe && mb && byte_mode) |=> ((dout & ~BYTE_LANES) == '0));
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!oe) |=> (dout == '0));
  assert_queue_R8: assert property (@(posedge clk) disable iff (rst)
    (oe && !mb) |=> (dout == $past(q_data)));
endmodule

// File: rtl/mbx_dual_mailbox.sv
module mbx_dual_mailbox #(
  parameter int unsigned WIDE_W   = mbx_pkg::WIDE_W_DEF,
  parameter int unsigned NARROW_W = mbx_pkg::NARROW_W_DEF,
  parameter int unsigned BYTE_W   = mbx_pkg::BYTE_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                size_b,
  input  logic                size_c,
  input  logic                a_en,
  input  logic                a_wr,
  input  logic                a_mb,
  input  logic                a_oe,
  input  logic [WIDE_W-1:0]   a_din,
  input  logic [WIDE_W-1:0]   a_q_dout,
  output logic [WIDE_W-1:0]   a_dout,
  input  logic                b_ren,
  input  logic                b_mb,
  input  logic                b_oe,
  input  logic [NARROW_W-1:0] b_q_dout,
  output logic [NARROW_W-1:0] b_dout,
  input  logic                c_wen,
  input  logic                c_mb,
  input  logic [NARROW_W-1:0] c_din,
  output logic                mb1_full_n,
  output logic                mb2_full_n,
  output logic                q1_push,
  output logic                q1_pop,
  output logic                q2_push,
  output logic                q2_pop
);
  import mbx_pkg::*;

  localparam int unsigned MAIL_W   = NARROW_W;
  localparam int unsigned RET_LO   = WIDE_W - MAIL_W;

  bus_size_e   sz_b, sz_c;
  logic        a_write, a_read;
  logic [MAIL_W-1:0] mail1, mail2;

  assign sz_b    = bus_size_e'(size_b);
  assign sz_c    = bus_size_e'(size_c);
  assign a_write = a_en & a_wr;
  assign a_read  = a_en & ~a_wr;

  assign q1_push = a_write & ~a_mb;
  assign q1_pop  = b_ren   & ~b_mb;
  assign q2_push = c_wen   & ~c_mb;
  assign q2_pop  = a_read  & ~a_mb;

  mbx_mail_slot #(.W(MAIL_W), .BW(BYTE_W)) u_fwd (
    .clk      (clk),
    .rst      (rst),
    .byte_mode(sz_b == SZ_BYTE),
    .wr_req   (a_write & a_mb),
    .wr_data  (a_din[MAIL_W-1:0]),
    .rd_req   (b_ren & b_mb),
    .data     (mail1),
    .full_n   (mb1_full_n)
  );

  mbx_mail_slot #(.W(MAIL_W), .BW(BYTE_W)) u_ret (
    .clk      (clk),
    .rst      (rst),
    .byte_mode(sz_c == SZ_BYTE),
    .wr_req   (c_wen & c_mb),
    .wr_data  (c_din),
    .rd_req   (a_read & a_mb),
    .data     (mail2),
    .full_n   (mb2_full_n)
  );

  mbx_out_steer #(.OUT_W(NARROW_W), .MAIL_W(MAIL_W), .LANE_LO(0), .BW(BYTE_W)) u_b_out (
    .clk      (clk),
    .rst      (rst),
    .oe       (b_oe),
    .mb       (b_mb),
    .byte_mode(sz_b == SZ_BYTE),
    .mail     (mail1),
    .q_data   (b_q_dout),
    .dout     (b_dout)
  );

  mbx_out_steer #(.OUT_W(WIDE_W), .MAIL_W(MAIL_W), .LANE_LO(RET_LO), .BW(BYTE_W)) u_a_out (
    .clk      (clk),
    .rst      (rst),
    .oe       (a_oe),
    .mb       (a_mb),
    .byte_mode(sz_c == SZ_BYTE),
    .mail     (mail2),
    .q_data   (a_q_dout),
    .dout     (a_dout)
  );

  assert_q_mail_excl_R9: assert property (@(posedge clk) disable iff (rst)
    (q1_push && !(b_ren && b_mb)) |=> $stable(mb1_full_n));
endmodule

// File: tb/sim_mbx_dual_mailbox.sv
module sim_mbx_dual_mailbox;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        to_a;
    logic        byte_mode;
    logic [35:0] din;
    logic [35:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 1'b0, {18'h2AAAA, 18'h1F0F3}, {18'h0, 18'h1F0F3}},
    '{1'b0, 1'b1, {18'h2AAAA, 18'h1F0F3}, {18'h0, 18'h000F3}},
    '{1'b0, 1'b1, {18'h00000, 18'h3FFFF}, {18'h0, 18'h001FF}},
    '{1'b1, 1'b0, {18'h0, 18'h2B5C7}, {18'h2B5C7, 18'h0}},
    '{1'b1, 1'b1, {18'h0, 18'h2B5C7}, {9'h0, 9'h1C7, 18'h0}},
    '{1'b1, 1'b1, {18'h0, 18'h3FFFF}, {9'h0, 9'h1FF, 18'h0}}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        size_b = 1'b0, size_c = 1'b0;
  logic        a_en = 0, a_wr = 0, a_mb = 0, a_oe = 0;
  logic [35:0] a_din = '0, a_q_dout = '0, a_dout;
  logic        b_ren = 0, b_mb = 0, b_oe = 0;
  logic [17:0] b_q_dout = '0, b_dout;
  logic        c_wen = 0, c_mb = 0;
  logic [17:0] c_din = '0;
  logic        mb1_full_n, mb2_full_n, q1_push, q1_pop, q2_push, q2_pop;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_dual_mailbox u0 (
    .clk(clk), .rst(rst), .size_b(size_b), .size_c(size_c),
    .a_en(a_en), .a_wr(a_wr), .a_mb(a_mb), .a_oe(a_oe),
    .a_din(a_din), .a_q_dout(a_q_dout), .a_dout(a_dout),
    .b_ren(b_ren), .b_mb(b_mb), .b_oe(b_oe), .b_q_dout(b_q_dout), .b_dout(b_dout),
    .c_wen(c_wen), .c_mb(c_mb), .c_din(c_din),
    .mb1_full_n(mb1_full_n), .mb2_full_n(mb2_full_n),
    .q1_push(q1_push), .q1_pop(q1_pop), .q2_push(q2_push), .q2_pop(q2_pop)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    a_en = 0; a_wr = 0; a_mb = 0; a_oe = 0;
    b_ren = 0; b_mb = 0; b_oe = 0;
    c_wen = 0; c_mb = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 mb1_full_n", 36'(mb1_full_n), 36'd1);
    chk("R1 mb2_full_n", 36'(mb2_full_n), 36'd1);
    chk("R1 a_dout", a_dout, 36'h0);
    chk("R1 b_dout", 36'(b_dout), 36'h0);
    b_ren = 1; b_mb = 1; b_oe = 1; cyc(); idle();
    chk("R1 mail1 zero", 36'(b_dout), 36'h0);

    // Vector table walk: R2 fill, R4 clear, R6/R7 lanes
    for (int i = 0; i < 6; i++) begin
      if (!VECS[i].to_a) begin
        size_b = VECS[i].byte_mode;
        a_en = 1; a_wr = 1; a_mb = 1; a_din = VECS[i].din; cyc(); idle();
        chk("R2 mb1 low", 36'(mb1_full_n), 36'd0);
        b_ren = 1; b_mb = 1; b_oe = 1; cyc(); idle();
        chk("R6 b lanes", 36'(b_dout), VECS[i].exp);
        chk("R4 mb1 high", 36'(mb1_full_n), 36'd1);
      end else begin
        size_c = VECS[i].byte_mode;
        c_wen = 1; c_mb = 1; c_din = VECS[i].din[17:0]; cyc(); idle();
        chk("R2 mb2 low", 36'(mb2_full_n), 36'd0);
        a_en = 1; a_wr = 0; a_mb = 1; a_oe = 1; cyc(); idle();
        chk("R7 a lanes", a_dout, VECS[i].exp);
        chk("R4 mb2 high", 36'(mb2_full_n), 36'd1);
      end
    end

    // R3: second write before read is dropped
    size_b = 0; size_c = 0;
    a_en = 1; a_wr = 1; a_mb = 1; a_din = 36'h11111; cyc(); idle();
    a_en = 1; a_wr = 1; a_mb = 1; a_din = 36'h22222; cyc(); idle();
    chk("R3 mb1 still low", 36'(mb1_full_n), 36'd0);
    b_ren = 1; b_mb = 1; b_oe = 1; cyc(); idle();
    chk("R3 first survives", 36'(b_dout), 36'h11111);
    c_wen = 1; c_mb = 1; c_din = 18'h0A5A5; cyc(); idle();
    c_wen = 1; c_mb = 1; c_din = 18'h35A5A; cyc(); idle();
    a_en = 1; a_mb = 1; a_oe = 1; cyc(); idle();
    chk("R3 mail2 first survives", a_dout, {18'h0A5A5, 18'h0});

    // R5: a second read returns the same word
    b_ren = 1; b_mb = 1; b_oe = 1; cyc(); idle();
    chk("R5 reread", 36'(b_dout), 36'h11111);
    chk("R5 flag stays high", 36'(mb1_full_n), 36'd1);

    // R4: write and read on one edge with flag high: write wins
    a_en = 1; a_wr = 1; a_mb = 1; a_din = 36'h2C3C3;
    b_ren = 1; b_mb = 1; b_oe = 1; cyc(); idle();
    chk("R4 write wins", 36'(mb1_full_n), 36'd0);
    // flag low: write dropped, read clears
    a_en = 1; a_wr = 1; a_mb = 1; a_din = 36'h33333;
    b_ren = 1; b_mb = 1; b_oe = 1; cyc(); idle();
    chk("R4 read clears", 36'(mb1_full_n), 36'd1);
    chk("R4 read data", 36'(b_dout), 36'h2C3C3);
    b_ren = 1; b_mb = 1; b_oe = 1; cyc(); idle();
    chk("R3 dropped under read", 36'(b_dout), 36'h2C3C3);

    // R8: output steering
    b_oe = 1; b_mb = 0; b_q_dout = 18'h0ABCD; cyc(); idle();
    chk("R8 b queue", 36'(b_dout), 36'h0ABCD);
    cyc();
    chk("R8 b oe low", 36'(b_dout), 36'h0);
    a_oe = 1; a_mb = 0; a_q_dout = 36'h987654321; cyc(); idle();
    chk("R8 a queue", a_dout, 36'h987654321);
    a_oe = 1; a_mb = 1; cyc(); idle();
    chk("R8 a mail", a_dout, {18'h0A5A5, 18'h0});

    // R9: queue strobes and no mailbox effect
    a_en = 1; a_wr = 1; a_mb = 0; a_din = 36'h3FFFF; #1;
    chk("R9 q1_push", {32'h0, q1_push, q1_pop, q2_push, q2_pop}, 36'b1000);
    cyc(); idle();
    chk("R9 mb1 untouched", 36'(mb1_full_n), 36'd1);
    a_en = 1; a_wr = 1; a_mb = 1; a_din = 36'h15555; #1;
    chk("R9 no strobe on mail", {32'h0, q1_push, q1_pop, q2_push, q2_pop}, 36'b0000);
    cyc(); idle();
    b_ren = 1; b_mb = 0; #1;
    chk("R9 q1_pop", {32'h0, q1_push, q1_pop, q2_push, q2_pop}, 36'b0100);
    cyc(); idle();
    chk("R9 mb1 kept by queue read", 36'(mb1_full_n), 36'd0);
    c_wen = 1; c_mb = 0; c_din = 18'h3FFFF; #1;
    chk("R9 q2_push", {32'h0, q1_push, q1_pop, q2_push, q2_pop}, 36'b0010);
    cyc(); idle();
    chk("R9 mb2 untouched", 36'(mb2_full_n), 36'd1);
    a_en = 1; a_wr = 0; a_mb = 0; #1;
    chk("R9 q2_pop", {32'h0, q1_push, q1_pop, q2_push, q2_pop}, 36'b0001);
    cyc(); idle();
    b_ren = 1; b_mb = 1; b_oe = 1; cyc(); idle();
    chk("R9 mail1 intact", 36'(b_dout), 36'h15555);

    summary();
    $finish;
  end
endmodule